// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the write path of a page-programmable nonvolatile memory. It watches every bus write cycle, each an address and a data byte, and picks out short unlock command sequences. A sequence always opens with the same two-cycle prefix. A third cycle then selects one of several commands. One code extends the sequence to six cycles to select a second set of commands. From these commands the block keeps a single global write-protection flag and enters or leaves an identification read mode. It also launches a chip erase.

Once protection is armed, a plain write with no prefix is refused. The block then holds off all further writes for a fixed lockout time. The three-cycle code that arms protection also opens a page-load window. While that window is open, byte loads reach the page loader through a one-cycle permit pulse, even with protection on. The window stays open as long as each load follows the previous one closely enough. With protection off, a write that breaks a sequence is passed through as an ordinary byte load. In identification mode, reads of two fixed addresses return a manufacturer code and a device code. All time intervals are parameters counted in clock cycles.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: After reset, prot_on, id_mode, lockout, load_ok and erase_start are 0 and id_data reads 00h.
- R2: Every command opens with data AAh written to address 5555h, followed by data 55h written to 2AAAh. Addresses are the 15-bit compare value. A cycle with the wrong address or data at any step returns the decoder to idle.
- R3: A third cycle of A0h at 5555h sets prot_on. It also opens a page window. A write taken no more than PAGE_WIN_CYC clock edges after the A0h edge, or after the previous load, pulses load_ok for one cycle and restarts the window. Repeating the A0h command while protection is on opens another window, and prot_on stays 1.
- R4: The six-cycle form is AAh, 55h, 80h, AAh, 55h and then a final code. The steps alternate between 5555h and 2AAAh, and the 80h and the final code both go to 5555h. A final code of 20h clears prot_on.
- R5: A six-cycle final code of 10h produces a one-cycle erase_start pulse in the cycle after the last write.
- R6: A three-cycle 90h code or a six-cycle 60h code sets id_mode. A three-cycle F0h code clears it. In each case id_mode changes ID_SETTLE_CYC clock edges after the final command write.
- R7: id_data is registered on rd_stb. In id_mode, a read of address 0 returns BFh and a read of address 1 returns DEV_CODE. Any other address, and any read outside id_mode, returns 00h.
- R8: With prot_on at 0, a write that breaks a sequence, including a write while idle that is not AAh at 5555h, pulses load_ok in the next cycle.
- R9: With prot_on at 1 and no page window open, a write that breaks a sequence is refused. lockout is then high for exactly LOCK_CYC cycles, and writes made during lockout have no effect.
- R10: Writes made while busy is high, or during an identification settle interval, have no effect. They do not advance the sequence, pulse load_ok, or start erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One write cycle per clock in which it is high |
| wr_addr | input | 15 | Compare address of the write cycle |
| wr_data | input | 8 | Data byte of the write cycle |
| rd_stb | input | 1 | Read strobe for identification data |
| rd_addr | input | 15 | Read address |
| busy | input | 1 | Internal write or erase in progress; write cycles are ignored |
| prot_on | output | 1 | Global write protection armed |
| id_mode | output | 1 | Identification read mode active |
| lockout | output | 1 | Refused-write hold-off in progress |
| load_ok | output | 1 | One-cycle permit for the page loader to take the byte |
| erase_start | output | 1 | One-cycle chip-erase launch |
| id_data | output | 8 | Registered identification read data |

## Verification
The assertions run on every cycle. They check that an erase launch is one cycle wide and that busy suppresses both load permits and erase launches in the following cycle. They also check that lockout only occurs while protection is armed, that it never overlaps a load permit and that it leaves id_mode untouched, and that id_data only ever carries one of the two identification codes. The bench scenarios cover the rest. They sweep every third-cycle code and every sixth-cycle code and check the result of each. They probe the exact boundary of the page window and the length of the lockout, and show that writes during busy, lockout or settle leave the sequence state unchanged.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] ADR_FIRST  = 15'h5555;
    localparam logic [CMD_AW-1:0] ADR_SECOND = 15'h2AAA;

    localparam logic [7:0] D_KEY1     = 8'hAA;
    localparam logic [7:0] D_KEY2     = 8'h55;
    localparam logic [7:0] D_PROTLOAD = 8'hA0;
    localparam logic [7:0] D_EXTEND   = 8'h80;
    localparam logic [7:0] D_IDENTER  = 8'h90;
    localparam logic [7:0] D_IDEXIT   = 8'hF0;
    localparam logic [7:0] D_UNPROT   = 8'h20;
    localparam logic [7:0] D_ERASE    = 8'h10;
    localparam logic [7:0] D_IDALT    = 8'h60;
    localparam logic [7:0] MFR_CODE   = 8'hBF;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_GOT1, SQ_GOT2, SQ_EXT3, SQ_EXT4, SQ_EXT5
    } seq_t;

    typedef enum logic [2:0] {
        EV_NONE, EV_STEP, EV_MISMATCH, EV_PROT_LOAD,
        EV_ID_ENTER, EV_ID_EXIT, EV_PROT_OFF, EV_ERASE
    } ev_t;

    typedef enum logic {HK_LOCK, HK_SETTLE} hold_t;

    function automatic logic hit(input logic [CMD_AW-1:0] a, input logic [7:0] d,
                                 input logic [CMD_AW-1:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic logic [7:0] id_pick(input logic [CMD_AW-1:0] a, input logic [7:0] dev);
        if (a == '0)
            return MFR_CODE;
        else if (a == CMD_AW'(1))
            return dev;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - W'(1);
    end
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
    import unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [CMD_AW-1:0] addr,
    input  logic [7:0]        data,
    output ev_t               ev
);
    seq_t state, state_nx;

    always_comb begin
        ev       = EV_NONE;
        state_nx = state;
        if (take) begin
            ev       = EV_MISMATCH;
            state_nx = SQ_IDLE;
            unique case (state)
                SQ_IDLE: if (hit(addr, data, ADR_FIRST, D_KEY1)) begin
                    ev = EV_STEP; state_nx = SQ_GOT1;
                end
                SQ_GOT1: if (hit(addr, data, ADR_SECOND, D_KEY2)) begin
                    ev = EV_STEP; state_nx = SQ_GOT2;
                end
                SQ_GOT2: if (addr == ADR_FIRST) begin
                    unique case (data)
                        D_PROTLOAD: ev = EV_PROT_LOAD;
                        D_IDENTER:  ev = EV_ID_ENTER;
                        D_IDEXIT:   ev = EV_ID_EXIT;
                        D_EXTEND:   begin ev = EV_STEP; state_nx = SQ_EXT3; end
                        default:    ev = EV_MISMATCH;
                    endcase
                end
                SQ_EXT3: if (hit(addr, data, ADR_FIRST, D_KEY1)) begin
                    ev = EV_STEP; state_nx = SQ_EXT4;
                end
                SQ_EXT4: if (hit(addr, data, ADR_SECOND, D_KEY2)) begin
                    ev = EV_STEP; state_nx = SQ_EXT5;
                end
                SQ_EXT5: if (addr == ADR_FIRST) begin
                    unique case (data)
                        D_UNPROT: ev = EV_PROT_OFF;
                        D_ERASE:  ev = EV_ERASE;
                        D_IDALT:  ev = EV_ID_ENTER;
                        default:  ev = EV_MISMATCH;
                    endcase
                end
                default: ev = EV_MISMATCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= SQ_IDLE;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/id_read_port.sv
module id_read_port
    import unlock_pkg::*;
#(
    parameter logic [7:0] DEV_CODE = 8'h5D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [CMD_AW-1:0] rd_addr,
    input  logic              id_mode,
    output logic [7:0]        id_data
);
    always_ff @(posedge clk) begin
        if (rst)
            id_data <= 8'h00;
        else if (rd_stb)
            id_data <= id_mode ? id_pick(rd_addr, DEV_CODE) : 8'h00;
    end
endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
    import unlock_pkg::*;
#(
    parameter int         PAGE_WIN_CYC  = 20000,
    parameter int         LOCK_CYC      = 30000,
    parameter int         ID_SETTLE_CYC = 1000,
    parameter logic [7:0] DEV_CODE      = 8'h5D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [14:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_stb,
    input  logic [14:0] rd_addr,
    input  logic        busy,
    output logic        prot_on,
    output logic        id_mode,
    output logic        lockout,
    output logic        load_ok,
    output logic        erase_start,
    output logic [7:0]  id_data
);
    localparam int PAGE_W   = $clog2(PAGE_WIN_CYC + 1);
    localparam int HOLD_MAX = (LOCK_CYC > ID_SETTLE_CYC) ? LOCK_CYC : ID_SETTLE_CYC;
    localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

    logic [PAGE_W-1:0] page_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    hold_t             hold_kind;
    logic              id_target;
    ev_t               ev;

    logic hold_active, page_open, accept, page_load, take;
    logic reject, pass, id_cmd, page_arm;

    assign hold_active = (hold_cnt != '0);
    assign page_open   = (page_cnt != '0);
    assign accept      = wr_stb && !busy && !hold_active;
    assign page_load   = accept && page_open;
    assign take        = accept && !page_open;

    assign reject   = take && (ev == EV_MISMATCH) && prot_on;
    assign pass     = take && (ev == EV_MISMATCH) && !prot_on;
    assign id_cmd   = take && ((ev == EV_ID_ENTER) || (ev == EV_ID_EXIT));
    assign page_arm = page_load || (take && (ev == EV_PROT_LOAD));

    seq_tracker u_seq (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .addr (wr_addr),
        .data (wr_data),
        .ev   (ev)
    );

    tick_timer #(.W(PAGE_W)) u_page_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (page_arm),
        .load_val (PAGE_W'(PAGE_WIN_CYC)),
        .count    (page_cnt)
    );

    tick_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (reject || id_cmd),
        .load_val (reject ? HOLD_W'(LOCK_CYC) : HOLD_W'(ID_SETTLE_CYC)),
        .count    (hold_cnt)
    );

    id_read_port #(.DEV_CODE(DEV_CODE)) u_id_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .id_mode (id_mode),
        .id_data (id_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_on     <= 1'b0;
            id_mode     <= 1'b0;
            id_target   <= 1'b0;
            hold_kind   <= HK_LOCK;
            load_ok     <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            load_ok     <= page_load || pass;
            erase_start <= take && (ev == EV_ERASE);
            if (take && (ev == EV_PROT_LOAD))
                prot_on <= 1'b1;
            else if (take && (ev == EV_PROT_OFF))
                prot_on <= 1'b0;
            if (reject)
                hold_kind <= HK_LOCK;
            else if (id_cmd) begin
                hold_kind <= HK_SETTLE;
                id_target <= (ev == EV_ID_ENTER);
            end
            if ((hold_kind == HK_SETTLE) && (hold_cnt == HOLD_W'(1)))
                id_mode <= id_target;
        end
    end

    assign lockout = hold_active && (hold_kind == HK_LOCK);

endmodule

// File: rtl/unlock_decoder_chk.sv
module unlock_decoder_chk #(
    parameter logic [7:0] DEV_CODE = 8'h5D
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       prot_on,
    input logic       id_mode,
    input logic       lockout,
    input logic       load_ok,
    input logic       erase_start,
    input logic [7:0] id_data
);
    a_r5_erase_single: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    a_r9_lock_needs_prot: assert property (@(posedge clk) disable iff (rst)
        lockout |-> prot_on);

    a_r9_no_load_in_lock: assert property (@(posedge clk) disable iff (rst)
        !(load_ok && lockout));

    a_r9_lock_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        lockout |=> $stable(id_mode));

    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!load_ok && !erase_start));

    a_r7_id_codes: assert property (@(posedge clk) disable iff (rst)
        (id_data != 8'h00) |-> ((id_data == 8'hBF) || (id_data == DEV_CODE)));
endmodule

bind cmd_unlock_decoder unlock_decoder_chk #(.DEV_CODE(DEV_CODE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .prot_on     (prot_on),
    .id_mode     (id_mode),
    .lockout     (lockout),
    .load_ok     (load_ok),
    .erase_start (erase_start),
    .id_data     (id_data)
);

// File: tb/test_cmd_unlock_decoder.sv
module test_cmd_unlock_decoder;
    localparam int         PW  = 6;
    localparam int         LK  = 8;
    localparam int         ST  = 4;
    localparam logic [7:0] DEV = 8'h3D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [14:0] rd_addr = '0;
    logic        busy = 1'b0;
    logic        prot_on, id_mode, lockout, load_ok, erase_start;
    logic [7:0]  id_data;

    int checks = 0;
    int errors = 0;
    logic s_load, s_erase, s_lock;
    logic [7:0] rdv;

    always #5 clk = ~clk;

    cmd_unlock_decoder #(
        .PAGE_WIN_CYC(PW), .LOCK_CYC(LK), .ID_SETTLE_CYC(ST), .DEV_CODE(DEV)
    ) i_cmd_unlock_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .busy(busy), .prot_on(prot_on),
        .id_mode(id_mode), .lockout(lockout), .load_ok(load_ok),
        .erase_start(erase_start), .id_data(id_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        s_load = load_ok; s_erase = erase_start; s_lock = lockout;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prefix();
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
    endtask

    task automatic cmd3(input logic [7:0] c);
        prefix();
        wr(15'h5555, c);
    endtask

    task automatic cmd6(input logic [7:0] c);
        prefix();
        wr(15'h5555, 8'h80);
        prefix();
        wr(15'h5555, c);
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = id_data;
    endtask

    task automatic wait_id(input logic exp);
        for (int j = 1; j < ST; j++) begin
            @(negedge clk);
            chk("R6 id_mode before settle ends", id_mode, !exp);
        end
        @(negedge clk);
        chk("R6 id_mode after settle", id_mode, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 prot_on", prot_on, 0);
        chk("R1 id_mode", id_mode, 0);
        chk("R1 lockout", lockout, 0);
        chk("R1 load_ok", load_ok, 0);
        chk("R1 erase_start", erase_start, 0);
        chk("R1 id_data", id_data, 0);

        // R8 plain write passes while unprotected
        wr(15'h0123, 8'h5A);
        chk("R8 plain write load", s_load, 1);

        // R2 wrong address at step two breaks the sequence
        wr(15'h5555, 8'hAA);
        wr(15'h5555, 8'h55);
        chk("R2 wrong second address passes", s_load, 1);
        prefix();
        wr(15'h2AAA, 8'hA0);
        chk("R2 wrong third address passes", s_load, 1);
        chk("R2 no protection", prot_on, 0);

        // sweep of every third-cycle code (R3 R6 R8)
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            logic known;
            cb = 8'(c);
            known = (cb == 8'hA0) || (cb == 8'h90) || (cb == 8'hF0) || (cb == 8'h80);
            cmd3(cb);
            chk("R8 third code pass-through", s_load, !known);
            if (cb == 8'hA0) begin
                chk("R3 protection armed", prot_on, 1);
                idle(PW + 1);
                cmd6(8'h20);
                chk("R4 protection cleared", prot_on, 0);
                chk("R4 no load", s_load, 0);
            end else if (cb == 8'h90) begin
                wait_id(1'b1);
                cmd3(8'hF0);
                wait_id(1'b0);
            end else if (cb == 8'hF0) begin
                idle(ST + 1);
                chk("R6 exit keeps read mode", id_mode, 0);
            end else if (cb == 8'h80) begin
                wr(15'h0010, 8'h33);
                chk("R8 break after extend passes", s_load, 1);
            end
            chk("R3 protection off in sweep", prot_on, 0);
        end

        // sweep of every sixth-cycle code (R4 R5 R6 R8)
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            logic known;
            cb = 8'(c);
            known = (cb == 8'h20) || (cb == 8'h10) || (cb == 8'h60);
            cmd6(cb);
            chk("R8 sixth code pass-through", s_load, !known);
            chk("R5 erase pulse", s_erase, cb == 8'h10);
            chk("R4 protection stays off", prot_on, 0);
            if (cb == 8'h10) begin
                @(negedge clk);
                chk("R5 erase pulse one cycle", erase_start, 0);
            end else if (cb == 8'h60) begin
                wait_id(1'b1);
                cmd3(8'hF0);
                wait_id(1'b0);
            end
        end

        // R7 identification reads and R10 settle ignores writes
        rd(15'h0000, rdv);
        chk("R7 read outside id mode", rdv, 8'h00);
        cmd3(8'h90);
        wr(15'h0123, 8'h44);
        chk("R10 write during settle ignored", s_load, 0);
        idle(ST);
        chk("R6 id_mode set", id_mode, 1);
        rd(15'h0000, rdv);
        chk("R7 manufacturer code", rdv, 8'hBF);
        rd(15'h0001, rdv);
        chk("R7 device code", rdv, DEV);
        rd(15'h0002, rdv);
        chk("R7 other address", rdv, 8'h00);
        rd(15'h7FFF, rdv);
        chk("R7 top address", rdv, 8'h00);
        cmd3(8'hF0);
        wait_id(1'b0);
        rd(15'h0001, rdv);
        chk("R7 read after exit", rdv, 8'h00);

        // R3 page window boundary, R9 lockout
        cmd3(8'hA0);
        chk("R3 armed", prot_on, 1);
        wr(15'h0200, 8'h11);
        chk("R3 first load", s_load, 1);
        idle(PW - 2);
        wr(15'h0201, 8'h22);
        chk("R3 load at window edge", s_load, 1);
        idle(PW - 1);
        wr(15'h0202, 8'h33);
        chk("R9 late write refused", s_load, 0);
        chk("R9 lockout raised", s_lock, 1);
        begin
            int n;
            n = 1;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (lockout) n++;
                else break;
            end
            chk("R9 lockout length", n, LK);
        end
        chk("R3 protection remains", prot_on, 1);

        wr(15'h0300, 8'h44);
        chk("R9 unprefixed write locks", s_lock, 1);
        wr(15'h5555, 8'hAA);
        chk("R9 write in lockout no load", s_load, 0);
        idle(LK);
        chk("R9 lockout over", lockout, 0);
        wr(15'h2AAA, 8'h55);
        chk("R9 key during lockout was ignored", s_lock, 1);
        idle(LK + 1);

        cmd3(8'hA0);
        wr(15'h0400, 8'h66);
        chk("R3 repeat command bypass load", s_load, 1);
        chk("R3 still protected", prot_on, 1);
        idle(PW + 1);

        prefix();
        wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h12);
        chk("R9 broken six-cycle refused", s_lock, 1);
        chk("R9 broken six-cycle no load", s_load, 0);
        idle(LK + 1);

        cmd6(8'h20);
        chk("R4 protection cleared", prot_on, 0);

        // R10 busy freezes the decoder
        busy = 1'b1;
        wr(15'h5555, 8'hAA);
        chk("R10 busy write no load", s_load, 0);
        wr(15'h1000, 8'h77);
        chk("R10 busy plain write no load", s_load, 0);
        busy = 1'b0;
        wr(15'h2AAA, 8'h55);
        chk("R10 key under busy was ignored", s_load, 1);
        prefix();
        wr(15'h5555, 8'h80);
        prefix();
        busy = 1'b1;
        wr(15'h5555, 8'h10);
        chk("R10 erase blocked by busy", s_erase, 0);
        busy = 1'b0;
        wr(15'h5555, 8'h10);
        chk("R5 erase after busy drops", s_erase, 1);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule